// File: doc/BRIEF.md
# Single-Cycle Datapath Control Decoder

This block is the steering logic of a single-cycle 64-bit processor. Each cycle it takes the instruction class code, the two register specifiers from the instruction, the branch decision and five datapath values. From these it works out four things: which register the first read port fetches, where the ALU result is written, what address and data the data memory sees, and which value becomes the next program counter. The register file, ALU and memory arrays sit outside. Only the selection logic is here, plus the program counter register that loads the chosen next address on every rising clock edge.

On stack operations (push, pop, call and return) the stack-pointer register is used in place of the register named by the instruction. The next address is picked from four candidates in a fixed order of precedence. Register index `{RID_W{1'b1}}` (0xF at the default width) means "no register", and the write enable for the result port drops when that index is selected.

Class codes used throughout: 0 halt, 1 nop, 2 conditional move, 3 immediate move, 4 store, 5 load, 6 ALU op, 7 jump, 8 call, 9 return, 0xA push, 0xB pop. Codes 0xC to 0xF are undefined. The stack pointer is register 4.

Top module: `seq_ctl_decoder`

## Requirements
- R1: `rd_addr_a` equals `reg_a` for codes 2, 4, 6 and 0xA, equals 4 for codes 9 and 0xB, and equals 0xF for every other code.
- R2: `wb_addr_e` equals `reg_b` for codes 2, 3 and 6, equals 4 for codes 8, 9, 0xA and 0xB, and equals 0xF for every other code.
- R3: `wb_en_e` is 1 exactly when `wb_addr_e` is not 0xF. This includes an ALU op whose `reg_b` is 0xF, which gives 0.
- R4: `dmem_addr` equals `alu_res` for codes 4, 5, 8 and 0xA, equals `opnd_a` for codes 9 and 0xB, and is zero otherwise.
- R5: `dmem_rd` is 1 only for codes 5, 9 and 0xB.
- R6: `dmem_wr` is 1 only for codes 4, 8 and 0xA. `dmem_wdata` is `opnd_a` for 4 and 0xA, `seq_pc` for 8, and zero otherwise.
- R7: `pc_next` is chosen in this order of precedence: `imm_val` for code 8; `imm_val` for code 7 with `take_br` high; `mem_rd_data` for code 9; `seq_pc` in all other cases. `take_br` has no effect on any code other than 7.
- R8: `pc_q` is 0 while `rst_n` is low, and after reset it takes the value `pc_next` had before each rising clock edge.
- R9: Undefined codes 0xC to 0xF produce no register access, no memory access and `pc_next` equal to `seq_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the PC register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Instruction class code |
| reg_a | input | RID_W | First register specifier |
| reg_b | input | RID_W | Second register specifier |
| take_br | input | 1 | Branch condition result |
| imm_val | input | XLEN | Constant word from the instruction |
| seq_pc | input | XLEN | Address of the following instruction |
| opnd_a | input | XLEN | Value read on port A |
| alu_res | input | XLEN | ALU result |
| mem_rd_data | input | XLEN | Data memory read value |
| rd_addr_a | output | RID_W | Register read port A address |
| wb_addr_e | output | RID_W | Write address for the ALU result |
| wb_en_e | output | 1 | Write enable for the ALU result |
| dmem_addr | output | XLEN | Data memory address |
| dmem_rd | output | 1 | Data memory read enable |
| dmem_wr | output | 1 | Data memory write enable |
| dmem_wdata | output | XLEN | Data memory write data |
| pc_next | output | XLEN | Selected next program counter |
| pc_q | output | XLEN | Registered program counter |

## Verification
The bench goes after jump with the branch flag clear and non-jump codes with the flag set. A design that ignores the flag, or applies it outside jumps, would send the PC to `imm_val` by mistake. It also drives an ALU op whose destination is 0xF: a decoder that enables the write from the class code alone would corrupt a register. Pop and return must read the stack pointer and use `opnd_a` as the address, while call must store `seq_pc`. A mix-up there would appear as the wrong address or data on the memory port. Undefined codes must fall through to `seq_pc` with all enables low, or the PC would jump on garbage.

// File: rtl/seq_ctl_pkg.sv
package seq_ctl_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_HALT  = 4'h0,
      OP_NOP   = 4'h1,
      OP_CMOV  = 4'h2,
      OP_IMOV  = 4'h3,
      OP_STORE = 4'h4,
      OP_LOAD  = 4'h5,
      OP_ALU   = 4'h6,
      OP_JUMP  = 4'h7,
      OP_CALL  = 4'h8,
      OP_RET   = 4'h9,
      OP_PUSH  = 4'hA,
      OP_POP   = 4'hB
   } op_t;
endpackage

// File: rtl/ctl_reg_sel.sv
module ctl_reg_sel
   import seq_ctl_pkg::*;
#(
   parameter int RID_W    = 4,
   parameter int STACK_ID = 4
) (
   input  logic [OPC_W-1:0] op,
   input  logic [RID_W-1:0] ra,
   input  logic [RID_W-1:0] rb,
   output logic [RID_W-1:0] src_a,
   output logic [RID_W-1:0] dst_e,
   output logic             dst_we
);
   localparam logic [RID_W-1:0] SP_ID   = RID_W'(STACK_ID);
   localparam logic [RID_W-1:0] NO_REG  = {RID_W{1'b1}};

   always_comb begin
      case (op)
         OP_CMOV, OP_STORE, OP_ALU, OP_PUSH: src_a = ra;
         OP_POP, OP_RET:                     src_a = SP_ID;
         default:                            src_a = NO_REG;
      endcase
   end

   always_comb begin
      case (op)
         OP_CMOV, OP_IMOV, OP_ALU:             dst_e = rb;
         OP_PUSH, OP_POP, OP_CALL, OP_RET:     dst_e = SP_ID;
         default:                              dst_e = NO_REG;
      endcase
   end

   assign dst_we = (dst_e != NO_REG);
endmodule

// File: rtl/ctl_mem_sel.sv
module ctl_mem_sel
   import seq_ctl_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [OPC_W-1:0] op,
   input  logic [XLEN-1:0]  alu_res,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  seq_pc,
   output logic [XLEN-1:0]  addr,
   output logic             rd,
   output logic             wr,
   output logic [XLEN-1:0]  wdata
);
   always_comb begin
      addr  = '0;
      rd    = 1'b0;
      wr    = 1'b0;
      wdata = '0;
      case (op)
         OP_STORE, OP_PUSH: begin
            addr  = alu_res;
            wr    = 1'b1;
            wdata = opnd_a;
         end
         OP_CALL: begin
            addr  = alu_res;
            wr    = 1'b1;
            wdata = seq_pc;
         end
         OP_LOAD: begin
            addr = alu_res;
            rd   = 1'b1;
         end
         OP_POP, OP_RET: begin
            addr = opnd_a;
            rd   = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ctl_pc_sel.sv
module ctl_pc_sel
   import seq_ctl_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [OPC_W-1:0] op,
   input  logic             take_br,
   input  logic [XLEN-1:0]  imm_val,
   input  logic [XLEN-1:0]  seq_pc,
   input  logic [XLEN-1:0]  mem_rd_data,
   output logic [XLEN-1:0]  nxt
);
   always_comb begin
      if (op == OP_CALL)                  nxt = imm_val;
      else if (op == OP_JUMP && take_br)  nxt = imm_val;
      else if (op == OP_RET)              nxt = mem_rd_data;
      else                                nxt = seq_pc;
   end
endmodule

// File: rtl/ctl_pc_reg.sv
module ctl_pc_reg #(
   parameter int              XLEN      = 64,
   parameter logic [XLEN-1:0] PC_RST    = '0,
   parameter bit              ASYNC_RST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] d,
   output logic [XLEN-1:0] q
);
   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= PC_RST;
            else        q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) q <= PC_RST;
            else        q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/seq_ctl_decoder.sv
module seq_ctl_decoder
   import seq_ctl_pkg::*;
#(
   parameter int  XLEN      = 64,
   parameter int  RID_W     = 4,
   parameter int  STACK_ID  = 4,
   parameter bit  ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_code,
   input  logic [RID_W-1:0] reg_a,
   input  logic [RID_W-1:0] reg_b,
   input  logic             take_br,
   input  logic [XLEN-1:0]  imm_val,
   input  logic [XLEN-1:0]  seq_pc,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  alu_res,
   input  logic [XLEN-1:0]  mem_rd_data,
   output logic [RID_W-1:0] rd_addr_a,
   output logic [RID_W-1:0] wb_addr_e,
   output logic             wb_en_e,
   output logic [XLEN-1:0]  dmem_addr,
   output logic             dmem_rd,
   output logic             dmem_wr,
   output logic [XLEN-1:0]  dmem_wdata,
   output logic [XLEN-1:0]  pc_next,
   output logic [XLEN-1:0]  pc_q
);
   localparam int MAX_ID = (1 << RID_W) - 1;

   generate
      if (XLEN < 8)              begin : g_bad_xlen  $error("XLEN must be at least 8"); end
      if (RID_W < 2)             begin : g_bad_rid   $error("RID_W must be at least 2"); end
      if (STACK_ID >= MAX_ID)    begin : g_bad_stack $error("STACK_ID collides with the no-register code"); end
   endgenerate

   ctl_reg_sel #(.RID_W(RID_W), .STACK_ID(STACK_ID)) u_reg (
      .op     (op_code),
      .ra     (reg_a),
      .rb     (reg_b),
      .src_a  (rd_addr_a),
      .dst_e  (wb_addr_e),
      .dst_we (wb_en_e)
   );

   ctl_mem_sel #(.XLEN(XLEN)) u_mem (
      .op      (op_code),
      .alu_res (alu_res),
      .opnd_a  (opnd_a),
      .seq_pc  (seq_pc),
      .addr    (dmem_addr),
      .rd      (dmem_rd),
      .wr      (dmem_wr),
      .wdata   (dmem_wdata)
   );

   ctl_pc_sel #(.XLEN(XLEN)) u_nxt (
      .op          (op_code),
      .take_br     (take_br),
      .imm_val     (imm_val),
      .seq_pc      (seq_pc),
      .mem_rd_data (mem_rd_data),
      .nxt         (pc_next)
   );

   ctl_pc_reg #(.XLEN(XLEN), .PC_RST('0), .ASYNC_RST(ASYNC_RST)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pc_next),
      .q     (pc_q)
   );
endmodule

// File: rtl/seq_ctl_chk.sv
module seq_ctl_chk #(
   parameter int XLEN     = 64,
   parameter int RID_W    = 4,
   parameter int STACK_ID = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       op_code,
   input logic [RID_W-1:0] rd_addr_a,
   input logic [RID_W-1:0] wb_addr_e,
   input logic             wb_en_e,
   input logic             dmem_rd,
   input logic             dmem_wr,
   input logic [XLEN-1:0]  dmem_wdata,
   input logic [XLEN-1:0]  seq_pc,
   input logic [XLEN-1:0]  mem_rd_data,
   input logic [XLEN-1:0]  pc_next,
   input logic [XLEN-1:0]  pc_q
);
   localparam logic [RID_W-1:0] SP_ID = RID_W'(STACK_ID);

   AST_STACK_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'h9 || op_code == 4'hB) |-> rd_addr_a == SP_ID); // R1

   AST_STACK_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code >= 4'h8 && op_code <= 4'hB) |-> wb_addr_e == SP_ID); // R2

   AST_NO_NULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_e |-> wb_addr_e != {RID_W{1'b1}}); // R3

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_rd && dmem_wr)); // R5

   AST_CALL_PUSHES_RET: assert property (@(posedge clk) disable iff (!rst_n)
      op_code == 4'h8 |-> (dmem_wr && dmem_wdata == seq_pc)); // R6

   AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      op_code == 4'h9 |-> pc_next == mem_rd_data); // R7

   AST_PC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pc_q == $past(pc_next)); // R8

   AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      op_code >= 4'hC |-> (!wb_en_e && !dmem_rd && !dmem_wr && pc_next == seq_pc)); // R9
endmodule

bind seq_ctl_decoder seq_ctl_chk #(.XLEN(XLEN), .RID_W(RID_W), .STACK_ID(STACK_ID)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_code     (op_code),
   .rd_addr_a   (rd_addr_a),
   .wb_addr_e   (wb_addr_e),
   .wb_en_e     (wb_en_e),
   .dmem_rd     (dmem_rd),
   .dmem_wr     (dmem_wr),
   .dmem_wdata  (dmem_wdata),
   .seq_pc      (seq_pc),
   .mem_rd_data (mem_rd_data),
   .pc_next     (pc_next),
   .pc_q        (pc_q)
);

// File: tb/sim_seq_ctl_decoder.sv
module sim_seq_ctl_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 64;
   localparam int RID_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       op_code = 4'h1;
   logic [RID_W-1:0] reg_a = '0, reg_b = '0;
   logic             take_br = 1'b0;
   logic [XLEN-1:0]  imm_val = '0, seq_pc = '0, opnd_a = '0, alu_res = '0, mem_rd_data = '0;
   logic [RID_W-1:0] rd_addr_a, wb_addr_e;
   logic             wb_en_e, dmem_rd, dmem_wr;
   logic [XLEN-1:0]  dmem_addr, dmem_wdata, pc_next, pc_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seq_ctl_decoder u0 (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .reg_a(reg_a), .reg_b(reg_b),
      .take_br(take_br), .imm_val(imm_val), .seq_pc(seq_pc), .opnd_a(opnd_a),
      .alu_res(alu_res), .mem_rd_data(mem_rd_data), .rd_addr_a(rd_addr_a),
      .wb_addr_e(wb_addr_e), .wb_en_e(wb_en_e), .dmem_addr(dmem_addr),
      .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_wdata(dmem_wdata),
      .pc_next(pc_next), .pc_q(pc_q)
   );

   function automatic logic [3:0] e_src(logic [3:0] op, logic [3:0] ra);
      case (op)
         4'h2, 4'h4, 4'h6, 4'hA: return ra;
         4'h9, 4'hB:             return 4'd4;
         default:                return 4'hF;
      endcase
   endfunction

   function automatic logic [3:0] e_dst(logic [3:0] op, logic [3:0] rb);
      case (op)
         4'h2, 4'h3, 4'h6:       return rb;
         4'h8, 4'h9, 4'hA, 4'hB: return 4'd4;
         default:                return 4'hF;
      endcase
   endfunction

   function automatic logic [63:0] e_maddr(logic [3:0] op);
      case (op)
         4'h4, 4'h5, 4'h8, 4'hA: return alu_res;
         4'h9, 4'hB:             return opnd_a;
         default:                return '0;
      endcase
   endfunction

   function automatic logic [63:0] e_wdata(logic [3:0] op);
      case (op)
         4'h4, 4'hA: return opnd_a;
         4'h8:       return seq_pc;
         default:    return '0;
      endcase
   endfunction

   function automatic logic [63:0] e_next(logic [3:0] op, logic br);
      if (op == 4'h8)           return imm_val;
      if (op == 4'h7 && br)     return imm_val;
      if (op == 4'h9)           return mem_rd_data;
      return seq_pc;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s op=%h actual=%h expected=%h", req, op_code, act, exp);
      end
   endtask

   task automatic check_comb();
      logic [3:0] d;
      d = e_dst(op_code, reg_b);
      chk("R1", 64'(rd_addr_a), 64'(e_src(op_code, reg_a)));
      chk("R2", 64'(wb_addr_e), 64'(d));
      chk("R3", 64'(wb_en_e), 64'(d != 4'hF));
      chk("R4", dmem_addr, e_maddr(op_code));
      chk("R5", 64'(dmem_rd), 64'(op_code == 4'h5 || op_code == 4'h9 || op_code == 4'hB));
      chk("R6", 64'(dmem_wr), 64'(op_code == 4'h4 || op_code == 4'h8 || op_code == 4'hA));
      chk("R6", dmem_wdata, e_wdata(op_code));
      chk("R7", pc_next, e_next(op_code, take_br));
      if (op_code >= 4'hC) begin
         chk("R9", 64'({wb_en_e, dmem_rd, dmem_wr}), 64'(0));
         chk("R9", pc_next, seq_pc);
      end
   endtask

   task automatic fill_random();
      imm_val     = {$urandom, $urandom};
      seq_pc      = {$urandom, $urandom};
      opnd_a      = {$urandom, $urandom};
      alu_res     = {$urandom, $urandom};
      mem_rd_data = {$urandom, $urandom};
   endtask

   task automatic step(logic [3:0] op, logic [3:0] ra, logic [3:0] rb, logic br);
      logic [63:0] want;
      @(negedge clk);
      op_code = op; reg_a = ra; reg_b = rb; take_br = br;
      fill_random();
      #1;
      check_comb();
      want = e_next(op, br);
      @(posedge clk);
      #1;
      chk("R8", pc_q, want);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      seq_pc = 64'h1234;
      repeat (3) @(posedge clk);
      #1;
      chk("R8", pc_q, 64'h0);   // reset value
      @(negedge clk);
      rst_n = 1'b1;
      // directed corner cases
      step(4'h7, 4'h1, 4'h2, 1'b0);   // R7 jump not taken
      step(4'h7, 4'h1, 4'h2, 1'b1);   // R7 jump taken
      step(4'h6, 4'h3, 4'hF, 1'b1);   // R3 null dest, R7 flag ignored
      step(4'h8, 4'h5, 4'h6, 1'b1);   // R6 call stores seq_pc
      step(4'h9, 4'h5, 4'h6, 1'b1);   // R7 return
      step(4'hB, 4'h0, 4'h0, 1'b0);   // R1 pop uses stack pointer
      step(4'hA, 4'h7, 4'h2, 1'b0);   // R6 push
      step(4'h5, 4'h2, 4'h3, 1'b0);   // R5 load
      for (int u = 12; u < 16; u++) step(4'(u), 4'h1, 4'h2, 1'b1); // R9
      for (int i = 0; i < 400; i++) begin
         logic [3:0] op;
         op = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 12);
         step(op, 4'($urandom), 4'($urandom), 1'($urandom));
      end
      // R8 reset during operation returns pc_q to 0
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R8", pc_q, 64'h0);
      finish_run();
   end
endmodule